// File: doc/BRIEF.md
# Dual Wiper Command Decoder

This block sits behind a byte-oriented SPI slave front end in a controller for two 256-position digital potentiometers. The front end marks the span of a frame with `frame_active`, presents each received byte with a one-cycle `byte_valid` strobe, and, once a stepping command is running, presents one `step_valid` strobe per serial clock pulse with the sampled serial-input level on `step_up`. The decoder checks the identity byte, decodes the instruction byte, and then acts on the two wiper positions and on a local mirror of the eight stored settings. A stored setting is written only when the frame closes, and the write is handed to a nonvolatile commit sequencer through a one-cycle request.

The control is one state machine with five named states. ST_ID waits for the identity byte. From there it goes to ST_INSTR on a match, or to ST_SKIP on a mismatch. ST_INSTR decodes the command byte. Commands that take a data byte or return a read byte go to ST_DATA. The stepping command goes to ST_STEP. Every other command, and every rejected command, goes to ST_SKIP. ST_DATA consumes the third byte and then goes to ST_SKIP. ST_STEP stays until the frame closes. ST_SKIP ignores all further bytes. Whenever `frame_active` is low the machine returns to ST_ID.

Read results are registered one cycle after the instruction byte is accepted. They are therefore ready well before the front end begins shifting out the third byte. Both wipers and every stored setting come out of reset at the value of the parameter `INIT_SETTING`, which models the power-up recall of setting 0.

Top module: `dpot_cmd_decoder`

## Requirements
- R1: An identity byte is accepted only if bits 7:4 are 0101, bits 3:2 are 00 and bits 1:0 equal `addr_pins`. Otherwise every later byte of that frame is ignored: no wiper change, no `rd_valid`, no `nv_req`.
- R2: In the instruction byte, bits 7:4 hold the opcode, bits 3:2 the setting index and bits 1:0 the pot index. Opcode 1001 (read wiper) raises `rd_valid` one cycle after the byte is accepted, with `rd_data` equal to the selected wiper. Both hold until the frame ends, and `rd_valid` is low in the cycle after `frame_active` is seen low.
- R3: Opcode 1010 (write wiper) loads the third byte into the selected wiper, visible one cycle after that byte.
- R4: Opcode 1011 (read setting) returns the mirror of setting [pot][index], with the same timing as R2.
- R5: Opcode 1100 (write setting) stages the third byte. In the cycle after `frame_active` is seen low, `nv_req` pulses for one cycle with `nv_mask` bit pot set, `nv_sel` = index, and the byte in the pot's 8-bit slot of `nv_data` (pot 0 in bits 7:0). The mirror is updated in that same cycle. If the frame ends before the third byte arrives, nothing is staged.
- R6: Opcode 1101 (two-byte frame) copies setting [pot][index] into that pot's wiper, visible one cycle after the instruction byte.
- R7: Opcode 1110 (two-byte frame) stages the selected wiper's current value for setting [pot][index] and commits it at frame end as in R5.
- R8: Opcode 0001 loads both wipers from their own setting [index], one cycle after the instruction byte.
- R9: Opcode 1000 stages both wipers for setting [index], and commits them at frame end with `nv_mask` = 11.
- R10: After opcode 0010, each `step_valid` moves the selected wiper one position: up if `step_up` is 1, down if it is 0. The wiper saturates at 255 and at 0. Stepping continues until the frame ends.
- R11: Opcode 0101 returns a byte whose bit 0 is `nv_busy` as sampled with the instruction byte, and whose bits 7:1 are 0.
- R12: An opcode outside the ten above, or a pot-selecting opcode with pot index 2 or 3, is ignored: no `rd_valid`, no wiper change, no `nv_req`.
- R13: After reset, both wipers read `INIT_SETTING`, every setting reads `INIT_SETTING`, and `rd_valid` and `nv_req` are low.
- R14: Bytes after a completed command, and any byte or step strobe while `frame_active` is low, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_pins | input | 2 | Strapped device address |
| frame_active | input | 1 | High while chip select is asserted |
| byte_valid | input | 1 | One-cycle strobe, a received byte is on byte_in |
| byte_in | input | 8 | Received byte |
| step_valid | input | 1 | One-cycle strobe per serial clock pulse during stepping |
| step_up | input | 1 | Serial input level for that pulse |
| nv_busy | input | 1 | Commit sequencer write in progress |
| rd_data | output | 8 | Byte to shift out as third byte |
| rd_valid | output | 1 | rd_data holds a read result for this frame |
| wiper_pos | output | 16 | Wiper positions, pot 0 in bits 7:0 |
| nv_req | output | 1 | One-cycle commit request |
| nv_mask | output | 2 | Pots written by the request |
| nv_sel | output | 2 | Setting index written |
| nv_data | output | 16 | Values to write, pot 0 in bits 7:0 |

## Verification
Two events can fall in the same cycle: the close of a frame and a pending stored-setting commit on one side, and a late step strobe or a stray byte on the other. The bench provokes this by raising `step_valid` or `byte_valid` in the very cycle `frame_active` drops, right after a stepping run and after a staged write. A behavioural reference model of wipers, settings and frame phase is advanced once per clock. It expects the commit pulse to appear, carrying the staged value, and it expects the late strobe to leave the wiper unchanged. Wipers, read outputs and commit outputs are compared with the model on every clock.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
package dpot_pkg;
    typedef enum logic [2:0] {
        ST_ID,
        ST_INSTR,
        ST_DATA,
        ST_STEP,
        ST_SKIP
    } dp_state_t;

    typedef struct packed {
        logic [3:0] op;
        logic [1:0] rs;
        logic [1:0] ps;
    } instr_t;

    localparam logic [3:0] TYPE_CODE   = 4'b0101;
    localparam logic [3:0] OP_RD_WIPER = 4'b1001;
    localparam logic [3:0] OP_WR_WIPER = 4'b1010;
    localparam logic [3:0] OP_RD_SET   = 4'b1011;
    localparam logic [3:0] OP_WR_SET   = 4'b1100;
    localparam logic [3:0] OP_SET2W    = 4'b1101;
    localparam logic [3:0] OP_W2SET    = 4'b1110;
    localparam logic [3:0] OP_GSET2W   = 4'b0001;
    localparam logic [3:0] OP_GW2SET   = 4'b1000;
    localparam logic [3:0] OP_STEP     = 4'b0010;
    localparam logic [3:0] OP_STATUS   = 4'b0101;
endpackage

// File: rtl/dpot_id_check.sv
`timescale 1ns/1ps
module dpot_id_check
    import dpot_pkg::*;
(
    input  logic [7:0] id_byte,
    input  logic [1:0] addr_pins,
    output logic       match
);
    always_comb begin
        match = (id_byte[7:4] == TYPE_CODE) && (id_byte[3:2] == 2'b00)
                && (id_byte[1:0] == addr_pins);
    end
endmodule

// File: rtl/dpot_wiper_bank.sv
`timescale 1ns/1ps
module dpot_wiper_bank #(
    parameter int W            = 8,
    parameter int NPOT         = 2,
    parameter int INIT_SETTING = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPOT-1:0]   load_mask,
    input  logic [NPOT*W-1:0] load_val,
    input  logic [NPOT-1:0]   step_mask,
    input  logic              step_up,
    output logic [NPOT*W-1:0] wiper
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        logic [W-1:0] pos;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pos <= W'(INIT_SETTING);
            end else if (load_mask[p]) begin
                pos <= load_val[p*W +: W];
            end else if (step_mask[p]) begin
                if (step_up && pos != TOP) begin
                    pos <= pos + 1'b1;
                end else if (!step_up && pos != '0) begin
                    pos <= pos - 1'b1;
                end
            end
        end

        assign wiper[p*W +: W] = pos;

        // R10: stepping never wraps at either end
        a_r10_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
            (step_mask[p] && !load_mask[p] && step_up && pos == TOP) |=> (pos == TOP));
        a_r10_sat_floor: assert property (@(posedge clk) disable iff (!rst_n)
            (step_mask[p] && !load_mask[p] && !step_up && pos == '0) |=> (pos == '0));
    end
endmodule

// File: rtl/dpot_store.sv
`timescale 1ns/1ps
module dpot_store #(
    parameter int W            = 8,
    parameter int NPOT         = 2,
    parameter int NREG         = 4,
    parameter int INIT_SETTING = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_active,
    input  logic                   stage,
    input  logic [NPOT-1:0]        stage_mask,
    input  logic [$clog2(NREG)-1:0] stage_sel,
    input  logic [NPOT*W-1:0]      stage_data,
    output logic [NPOT*NREG*W-1:0] set_all,
    output logic                   nv_req,
    output logic [NPOT-1:0]        nv_mask,
    output logic [$clog2(NREG)-1:0] nv_sel,
    output logic [NPOT*W-1:0]      nv_data
);
    localparam int SW = $clog2(NREG);

    logic [W-1:0]      mem [NPOT][NREG];
    logic              pend;
    logic [NPOT-1:0]   pend_mask;
    logic [SW-1:0]     pend_sel;
    logic [NPOT*W-1:0] pend_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_mask <= '0;
            pend_sel  <= '0;
            pend_data <= '0;
            nv_req    <= 1'b0;
            nv_mask   <= '0;
            nv_sel    <= '0;
            nv_data   <= '0;
            for (int p = 0; p < NPOT; p++) begin
                for (int r = 0; r < NREG; r++) begin
                    mem[p][r] <= W'(INIT_SETTING);
                end
            end
        end else begin
            nv_req <= 1'b0;
            if (frame_active) begin
                if (stage) begin
                    pend      <= 1'b1;
                    pend_mask <= stage_mask;
                    pend_sel  <= stage_sel;
                    pend_data <= stage_data;
                end
            end else if (pend) begin
                pend    <= 1'b0;
                nv_req  <= 1'b1;
                nv_mask <= pend_mask;
                nv_sel  <= pend_sel;
                nv_data <= pend_data;
                for (int p = 0; p < NPOT; p++) begin
                    if (pend_mask[p]) begin
                        mem[p][pend_sel] <= pend_data[p*W +: W];
                    end
                end
            end
        end
    end

    for (genvar p = 0; p < NPOT; p++) begin : g_p
        for (genvar r = 0; r < NREG; r++) begin : g_r
            assign set_all[(p*NREG + r)*W +: W] = mem[p][r];
        end
    end

    // R5: a commit is requested only once the frame has closed
    a_r5_commit_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |-> !$past(frame_active));
    // R5: each commit is a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |=> !nv_req);
endmodule

// File: rtl/dpot_cmd_decoder.sv
`timescale 1ns/1ps
module dpot_cmd_decoder
    import dpot_pkg::*;
#(
    parameter int W            = 8,
    parameter int NPOT         = 2,
    parameter int NREG         = 4,
    parameter int INIT_SETTING = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_pins,
    input  logic              frame_active,
    input  logic              byte_valid,
    input  logic [W-1:0]      byte_in,
    input  logic              step_valid,
    input  logic              step_up,
    input  logic              nv_busy,
    output logic [W-1:0]      rd_data,
    output logic              rd_valid,
    output logic [NPOT*W-1:0] wiper_pos,
    output logic              nv_req,
    output logic [NPOT-1:0]   nv_mask,
    output logic [1:0]        nv_sel,
    output logic [NPOT*W-1:0] nv_data
);
    dp_state_t state, state_nx;
    instr_t    instr, cmd_q;
    logic      id_ok, pot_ok;
    int        pot_i, cmd_pot, rs_i;

    logic [NPOT-1:0]        ld_mask, step_mask, stage_mask;
    logic [NPOT*W-1:0]      ld_val, stage_data;
    logic                   stage, rd_load;
    logic [1:0]             stage_sel;
    logic [W-1:0]           rd_val;
    logic [NPOT*NREG*W-1:0] set_all;

    assign instr   = instr_t'(byte_in);
    assign pot_ok  = int'(instr.ps) < NPOT;
    assign pot_i   = pot_ok ? int'(instr.ps) : 0;
    assign rs_i    = int'(instr.rs);
    assign cmd_pot = (int'(cmd_q.ps) < NPOT) ? int'(cmd_q.ps) : 0;

    dpot_id_check u_id (
        .id_byte   (byte_in[7:0]),
        .addr_pins (addr_pins),
        .match     (id_ok)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ID:    if (byte_valid) state_nx = id_ok ? ST_INSTR : ST_SKIP;
            ST_INSTR: if (byte_valid) begin
                state_nx = ST_SKIP;
                case (instr.op)
                    OP_RD_WIPER, OP_WR_WIPER, OP_RD_SET, OP_WR_SET:
                        if (pot_ok) state_nx = ST_DATA;
                    OP_STATUS: state_nx = ST_DATA;
                    OP_STEP:   if (pot_ok) state_nx = ST_STEP;
                    default: ;
                endcase
            end
            ST_DATA:  if (byte_valid) state_nx = ST_SKIP;
            ST_STEP:  ;
            ST_SKIP:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ID;
        else        state <= frame_active ? state_nx : ST_ID;
    end

    // control outputs
    always_comb begin
        ld_mask    = '0;
        ld_val     = '0;
        step_mask  = '0;
        stage      = 1'b0;
        stage_mask = '0;
        stage_sel  = instr.rs;
        stage_data = wiper_pos;
        rd_load    = 1'b0;
        rd_val     = '0;
        if (frame_active) begin
            unique case (state)
                ST_INSTR: if (byte_valid) begin
                    case (instr.op)
                        OP_RD_WIPER: if (pot_ok) begin
                            rd_load = 1'b1;
                            rd_val  = wiper_pos[pot_i*W +: W];
                        end
                        OP_RD_SET: if (pot_ok) begin
                            rd_load = 1'b1;
                            rd_val  = set_all[(pot_i*NREG + rs_i)*W +: W];
                        end
                        OP_STATUS: begin
                            rd_load = 1'b1;
                            rd_val  = {{(W-1){1'b0}}, nv_busy};
                        end
                        OP_SET2W: if (pot_ok) begin
                            ld_mask[pot_i]        = 1'b1;
                            ld_val[pot_i*W +: W]  = set_all[(pot_i*NREG + rs_i)*W +: W];
                        end
                        OP_GSET2W: begin
                            ld_mask = '1;
                            for (int p = 0; p < NPOT; p++) begin
                                ld_val[p*W +: W] = set_all[(p*NREG + rs_i)*W +: W];
                            end
                        end
                        OP_W2SET: if (pot_ok) begin
                            stage             = 1'b1;
                            stage_mask[pot_i] = 1'b1;
                        end
                        OP_GW2SET: begin
                            stage      = 1'b1;
                            stage_mask = '1;
                        end
                        default: ;
                    endcase
                end
                ST_DATA: if (byte_valid) begin
                    if (cmd_q.op == OP_WR_WIPER) begin
                        ld_mask[cmd_pot] = 1'b1;
                        ld_val           = {NPOT{byte_in}};
                    end else if (cmd_q.op == OP_WR_SET) begin
                        stage               = 1'b1;
                        stage_mask[cmd_pot] = 1'b1;
                        stage_sel           = cmd_q.rs;
                        stage_data          = {NPOT{byte_in}};
                    end
                end
                ST_STEP: if (step_valid) step_mask[cmd_pot] = 1'b1;
                ST_ID, ST_SKIP: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (frame_active && state == ST_INSTR && byte_valid) cmd_q <= instr;
            if (!frame_active) begin
                rd_valid <= 1'b0;
            end else if (rd_load) begin
                rd_valid <= 1'b1;
                rd_data  <= rd_val;
            end
        end
    end

    dpot_wiper_bank #(.W(W), .NPOT(NPOT), .INIT_SETTING(INIT_SETTING)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_mask (ld_mask),
        .load_val  (ld_val),
        .step_mask (step_mask),
        .step_up   (step_up),
        .wiper     (wiper_pos)
    );

    dpot_store #(.W(W), .NPOT(NPOT), .NREG(NREG), .INIT_SETTING(INIT_SETTING)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_active (frame_active),
        .stage        (stage),
        .stage_mask   (stage_mask),
        .stage_sel    (stage_sel),
        .stage_data   (stage_data),
        .set_all      (set_all),
        .nv_req       (nv_req),
        .nv_mask      (nv_mask),
        .nv_sel       (nv_sel),
        .nv_data      (nv_data)
    );

    // R2: read result is dropped once the frame closes
    a_r2_read_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |=> !rd_valid);
    // R11: status byte carries only the busy flag
    a_r11_status_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && state == ST_INSTR && byte_valid && instr.op == OP_STATUS)
        |=> (rd_valid && rd_data[W-1:1] == '0 && rd_data[0] == $past(nv_busy)));
    // R12: a read naming a missing pot produces no read byte
    a_r12_bad_pot_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && state == ST_INSTR && byte_valid && !pot_ok
         && (instr.op == OP_RD_WIPER || instr.op == OP_RD_SET)) |=> !rd_valid);
    // R1: a rejected identity byte never leads to a read byte
    a_r1_reject_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && state == ST_ID && byte_valid && !id_ok) |=> !rd_valid);
endmodule

// File: tb/tb_dpot_cmd_decoder.sv
`timescale 1ns/1ps
module tb_dpot_cmd_decoder;
    localparam logic [1:0] ADDR = 2'b10;
    localparam logic [7:0] IDB  = 8'h52;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_active = 1'b0, byte_valid = 1'b0, step_valid = 1'b0;
    logic        step_up = 1'b0, nv_busy = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [7:0]  rd_data;
    logic        rd_valid, nv_req;
    logic [15:0] wiper_pos, nv_data;
    logic [1:0]  nv_mask, nv_sel;

    always #10 clk = ~clk;

    dpot_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr_pins(ADDR), .frame_active(frame_active),
        .byte_valid(byte_valid), .byte_in(byte_in), .step_valid(step_valid),
        .step_up(step_up), .nv_busy(nv_busy), .rd_data(rd_data), .rd_valid(rd_valid),
        .wiper_pos(wiper_pos), .nv_req(nv_req), .nv_mask(nv_mask), .nv_sel(nv_sel),
        .nv_data(nv_data)
    );

    // behavioural reference state
    int    mw [2];
    int    mset [2][4];
    bit    e_rdv, e_nvq, pend;
    int    e_rdd, e_mask, e_sel, pmask, psel;
    int    e_nvd [2];
    int    pd [2];
    int    phase, mop, mrs, mps;
    string cur_req = "R13";
    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("wiper0", int'(wiper_pos[7:0]), mw[0]);
        check("wiper1", int'(wiper_pos[15:8]), mw[1]);
        check("rd_valid", int'(rd_valid), int'(e_rdv));
        if (e_rdv) check("rd_data", int'(rd_data), e_rdd);
        check("nv_req", int'(nv_req), int'(e_nvq));
        if (e_nvq) begin
            check("nv_mask", int'(nv_mask), e_mask);
            check("nv_sel", int'(nv_sel), e_sel);
            if (e_mask[0]) check("nv_data0", int'(nv_data[7:0]), e_nvd[0]);
            if (e_mask[1]) check("nv_data1", int'(nv_data[15:8]), e_nvd[1]);
        end
    endtask

    task automatic model_step(bit fa, bit bv, logic [7:0] b, bit sv, bit su);
        int op, rs, ps;
        bit ok;
        e_nvq = 1'b0;
        if (!fa) begin
            e_rdv = 1'b0;
            if (pend) begin
                for (int p = 0; p < 2; p++) if (pmask[p]) mset[p][psel] = pd[p];
                e_nvq = 1'b1; e_mask = pmask; e_sel = psel; e_nvd = pd; pend = 1'b0;
            end
            phase = 0;
            return;
        end
        if (phase == 3) begin
            if (sv) begin
                if (su && mw[mps] < 255) mw[mps]++;
                else if (!su && mw[mps] > 0) mw[mps]--;
            end
            return;
        end
        if (!bv) return;
        op = int'(b[7:4]); rs = int'(b[3:2]); ps = int'(b[1:0]); ok = (ps < 2);
        case (phase)
            0: phase = (b[7:2] == 6'b010100 && b[1:0] == ADDR) ? 1 : 4;
            1: begin
                mop = op; mrs = rs; mps = ps; phase = 4;
                case (op)
                    9:  if (ok) begin e_rdv = 1; e_rdd = mw[ps]; phase = 2; end
                    11: if (ok) begin e_rdv = 1; e_rdd = mset[ps][rs]; phase = 2; end
                    10, 12: if (ok) phase = 2;
                    5:  begin e_rdv = 1; e_rdd = int'(nv_busy); phase = 2; end
                    13: if (ok) mw[ps] = mset[ps][rs];
                    14: if (ok) begin pend = 1; pmask = 1 << ps; psel = rs; pd[ps] = mw[ps]; end
                    1:  begin mw[0] = mset[0][rs]; mw[1] = mset[1][rs]; end
                    8:  begin pend = 1; pmask = 3; psel = rs; pd[0] = mw[0]; pd[1] = mw[1]; end
                    2:  if (ok) phase = 3;
                    default: ;
                endcase
            end
            2: begin
                if (mop == 10) mw[mps] = int'(b);
                else if (mop == 12) begin pend = 1; pmask = 1 << mps; psel = mrs; pd[mps] = int'(b); end
                phase = 4;
            end
            default: ;
        endcase
    endtask

    task automatic cyc(bit fa, bit bv, logic [7:0] b, bit sv, bit su);
        frame_active = fa; byte_valid = bv; byte_in = b; step_valid = sv; step_up = su;
        model_step(fa, bv, b, sv, su);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 0);
    endtask
    task automatic sb(logic [7:0] b);
        cyc(1, 1, b, 0, 0);
        cyc(1, 0, 8'h00, 0, 0);
    endtask
    task automatic frame2(logic [3:0] op, logic [1:0] rs, logic [1:0] ps);
        cyc(1, 0, 8'h00, 0, 0); sb(IDB); sb({op, rs, ps}); idle(2);
    endtask
    task automatic frame3(logic [3:0] op, logic [1:0] rs, logic [1:0] ps, logic [7:0] d);
        cyc(1, 0, 8'h00, 0, 0); sb(IDB); sb({op, rs, ps}); sb(d); idle(2);
    endtask
    task automatic step(bit up);
        cyc(1, 0, 8'h00, 1, up);
    endtask

    initial begin
        for (int p = 0; p < 2; p++) begin
            mw[p] = 128; pd[p] = 0; e_nvd[p] = 0;
            for (int r = 0; r < 4; r++) mset[p][r] = 128;
        end
        e_rdv = 0; e_nvq = 0; pend = 0; phase = 0; e_rdd = 0;
        e_mask = 0; e_sel = 0; pmask = 0; psel = 0; mop = 0; mrs = 0; mps = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R13"; compare_all(); idle(2);
        frame3(4'b1011, 2'd3, 2'd1, 8'h00);           // setting read after reset

        cur_req = "R3";  frame3(4'b1010, 2'd0, 2'd0, 8'h3C);
        frame3(4'b1010, 2'd0, 2'd1, 8'hF0);
        cur_req = "R1";
        cyc(1, 0, 0, 0, 0); sb(8'h62); sb(8'hA0); sb(8'h11); idle(2);   // wrong type
        cyc(1, 0, 0, 0, 0); sb(8'h51); sb(8'hA0); sb(8'h22); idle(2);   // wrong address
        cyc(1, 0, 0, 0, 0); sb(8'h56); sb(8'h90); sb(8'h00); idle(2);   // bits 3:2 set
        cur_req = "R2";  frame3(4'b1001, 2'd0, 2'd1, 8'h00);
        frame3(4'b1001, 2'd2, 2'd0, 8'h00);
        cur_req = "R5";  frame3(4'b1100, 2'd2, 2'd0, 8'h5A);
        cyc(1, 0, 0, 0, 0); sb(IDB); sb(8'hC5); idle(2);              // aborted write
        cur_req = "R4";  frame3(4'b1011, 2'd2, 2'd0, 8'h00);
        frame3(4'b1011, 2'd1, 2'd1, 8'h00);
        cur_req = "R6";  frame2(4'b1101, 2'd2, 2'd0);
        cur_req = "R7";  frame2(4'b1110, 2'd3, 2'd1);
        frame3(4'b1011, 2'd3, 2'd1, 8'h00);
        cur_req = "R5";  frame3(4'b1100, 2'd1, 2'd1, 8'h07);
        cur_req = "R8";  frame2(4'b0001, 2'd1, 2'd0);
        cur_req = "R9";  frame3(4'b1010, 2'd0, 2'd0, 8'h99);
        frame2(4'b1000, 2'd0, 2'd0);
        frame3(4'b1011, 2'd0, 2'd0, 8'h00);
        frame3(4'b1011, 2'd0, 2'd1, 8'h00);
        cur_req = "R10";
        frame3(4'b1010, 2'd0, 2'd0, 8'hFD);
        cyc(1, 0, 0, 0, 0); sb(IDB); sb(8'h20);
        for (int i = 0; i < 4; i++) step(1);                          // saturate high
        step(0); step(0); step(1);
        cur_req = "R14"; cyc(0, 0, 8'h00, 1, 1); idle(1);              // late strobe
        cur_req = "R10";
        frame3(4'b1010, 2'd0, 2'd1, 8'h01);
        cyc(1, 0, 0, 0, 0); sb(IDB); sb(8'h21);
        for (int i = 0; i < 3; i++) step(0);                          // saturate low
        step(1); idle(2);
        cur_req = "R11"; nv_busy = 1'b1; frame3(4'b0101, 2'd0, 2'd1, 8'h00);
        nv_busy = 1'b0; frame3(4'b0101, 2'd0, 2'd1, 8'h00);
        cur_req = "R12";
        frame3(4'b0011, 2'd0, 2'd0, 8'h44);
        frame3(4'b1001, 2'd0, 2'd2, 8'h00);
        frame3(4'b1010, 2'd0, 2'd3, 8'h55);
        frame2(4'b1110, 2'd1, 2'd2);
        frame3(4'b1011, 2'd1, 2'd0, 8'h00);
        cur_req = "R14";
        cyc(1, 0, 0, 0, 0); sb(IDB); sb(8'hA0); sb(8'h66); sb(8'h52); sb(8'hA0); sb(8'h11);
        cyc(0, 1, 8'h52, 0, 0); idle(1);
        cur_req = "R5";                                                // commit with late byte
        cyc(1, 0, 0, 0, 0); sb(IDB); sb(8'hCC); sb(8'h3E);
        cyc(0, 1, 8'hA1, 1, 0); idle(2);
        frame3(4'b1011, 2'd3, 2'd0, 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule